// File: doc/BRIEF.md
# USB OUT receive buffer manager

This block sits between a full-speed USB device packet engine and the packet memory on the receive side. The memory is split into fixed 64-byte buffers, each named by a small buffer ID. Software keeps a free-buffer FIFO topped up with IDs. When the host sends an OUT or SETUP data packet, the block reserves the ID at the head of that FIFO and produces a byte write address for every received byte. When the packet ends with a good CRC, it pushes a descriptor into a received-packet FIFO that software drains.

For every packet the block also picks the handshake. A packet is accepted only if three things hold when its token arrives: a free buffer is available, the received FIFO has room, and, for OUT packets, reception is enabled on the endpoint. OUT packets that cannot be accepted are answered with NAK. SETUP packets that cannot be accepted are dropped silently. Packets with a bad CRC are always dropped silently. The buffer ID leaves the free FIFO only when the packet is accepted.

Top module: `usb_rx_buf_mgr`

## Requirements
- R1: Buffer IDs span 0 to MEM_BYTES/MAX_PKT-1 (0..31 by default). The byte address written is ID*MAX_PKT plus the byte index within the packet, counted from 0 after the token.
- R2: A good-CRC OUT packet is answered with NAK (hs_o=2) if, at its token, the free FIFO was empty or the received FIFO was full.
- R3: Under the same conditions a good-CRC SETUP packet gets no handshake (hs_o=0) and leaves both FIFOs unchanged.
- R4: A packet with a bad CRC, or with fewer than 2 bytes, gets hs_o=0 and changes neither FIFO.
- R5: An accepted packet gets ACK (hs_o=1) and pushes a descriptor holding the buffer ID, the byte length, the endpoint and a SETUP flag (1 = SETUP, 0 = OUT).
- R6: The stored length is the received byte count minus the 2 CRC bytes and may be 0. Every received byte, CRC included, is written while its index is below MAX_PKT. Bytes at index MAX_PKT or above are not written.
- R7: pkt_rcvd_o is high exactly while the received FIFO holds at least one entry.
- R8: An OUT packet to an endpoint whose out_en_i bit is 0 gets NAK and nothing is written. SETUP packets ignore out_en_i.
- R9: A buffer ID is popped from the free FIFO only when a packet is accepted. Any drop or NAK leaves the ID at the head.
- R10: Both FIFOs hold FIFO_DEPTH (4) entries. A software push into a full FIFO is ignored, and a pop from an empty FIFO is ignored. The full and empty flags reflect the occupancy.
- R11: hs_valid_o pulses for one cycle, in the cycle after eop_i, with the handshake in hs_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tok_valid_i | input | 1 | Data-phase token strobe |
| tok_ep_i | input | EP_W | Endpoint of the token |
| tok_setup_i | input | 1 | 1 = SETUP, 0 = OUT |
| byte_valid_i | input | 1 | One received byte (data or CRC) |
| eop_i | input | 1 | End of packet strobe |
| crc_ok_i | input | 1 | CRC status, qualified by eop_i |
| out_en_i | input | NUM_EP | Per-endpoint OUT reception enable |
| av_push_i | input | 1 | Software push strobe for the free FIFO |
| av_id_i | input | ID_W | Buffer ID to push |
| av_full_o | output | 1 | Free FIFO full |
| av_empty_o | output | 1 | Free FIFO empty |
| rx_pop_i | input | 1 | Software pop strobe for the received FIFO |
| rx_id_o | output | ID_W | Head descriptor: buffer ID |
| rx_len_o | output | LEN_W | Head descriptor: data length |
| rx_ep_o | output | EP_W | Head descriptor: endpoint |
| rx_setup_o | output | 1 | Head descriptor: SETUP flag |
| rx_full_o | output | 1 | Received FIFO full |
| rx_empty_o | output | 1 | Received FIFO empty |
| pkt_rcvd_o | output | 1 | Packet-received interrupt |
| wr_en_o | output | 1 | Packet memory byte write enable |
| wr_addr_o | output | ADDR_W | Packet memory byte address |
| hs_valid_o | output | 1 | Handshake decision valid |
| hs_o | output | 2 | 0 none, 1 ACK, 2 NAK |

## Verification
The bench builds the block with its defaults: 2048 bytes of memory, 64-byte buffers, 16 endpoints and 4-deep FIFOs. The shallow FIFOs let a handful of packets reach the full received FIFO and the empty free FIFO, so both refusal paths are easy to hit. The 64-byte buffer puts the CRC bytes of a maximum-length packet past the buffer end, and the 32-entry ID space lets directed IDs 0 and 31 check the address edges.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {
    HS_NONE = 2'd0,
    HS_ACK  = 2'd1,
    HS_NAK  = 2'd2
  } hs_e;
endpackage

// File: rtl/rx_sfifo.sv
module rx_sfifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_push_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_push |=> !empty_o);
endmodule

// File: rtl/rx_pkt_ctrl.sv
module rx_pkt_ctrl import usb_rx_pkg::*; #(
  parameter int NUM_EP = 16,
  parameter int ID_W   = 5,
  parameter int OFF_W  = 6,
  localparam int EP_W  = $clog2(NUM_EP),
  localparam int LEN_W = OFF_W + 1,
  localparam int CNT_W = OFF_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_valid_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              tok_setup_i,
  input  logic              byte_valid_i,
  input  logic              eop_i,
  input  logic              crc_ok_i,
  input  logic [NUM_EP-1:0] out_en_i,
  input  logic              av_empty_i,
  input  logic [ID_W-1:0]   av_id_i,
  input  logic              rx_full_i,
  output logic              wr_en_o,
  output logic [ID_W+OFF_W-1:0] wr_addr_o,
  output logic              hs_valid_o,
  output hs_e               hs_o,
  output logic              av_pop_o,
  output logic              rx_push_o,
  output logic [ID_W-1:0]   d_id_o,
  output logic [LEN_W-1:0]  d_len_o,
  output logic [EP_W-1:0]   d_ep_o,
  output logic              d_setup_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(2 ** OFF_W);

  logic             busy_q, held_q, setup_q, hs_valid_q;
  logic [EP_W-1:0]  ep_q;
  logic [ID_W-1:0]  id_q;
  logic [CNT_W-1:0] cnt_q;
  hs_e              hs_q;
  logic             fin, good, held_d;

  // space and enable are judged once, at the token
  assign held_d = !av_empty_i && !rx_full_i && (tok_setup_i || out_en_i[tok_ep_i]);
  assign fin    = busy_q && eop_i;
  assign good   = fin && crc_ok_i && (cnt_q >= CNT_W'(2));

  assign wr_en_o   = busy_q && held_q && byte_valid_i && (cnt_q < MAX_CNT);
  assign wr_addr_o = {id_q, cnt_q[OFF_W-1:0]};

  assign rx_push_o = good && held_q;
  assign av_pop_o  = good && held_q;
  assign d_id_o    = id_q;
  assign d_len_o   = LEN_W'(cnt_q - CNT_W'(2));
  assign d_ep_o    = ep_q;
  assign d_setup_o = setup_q;

  assign hs_valid_o = hs_valid_q;
  assign hs_o       = hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      held_q     <= 1'b0;
      setup_q    <= 1'b0;
      ep_q       <= '0;
      id_q       <= '0;
      cnt_q      <= '0;
      hs_valid_q <= 1'b0;
      hs_q       <= HS_NONE;
    end else begin
      hs_valid_q <= fin;
      if (fin) begin
        busy_q <= 1'b0;
        if (!good)       hs_q <= HS_NONE;
        else if (held_q) hs_q <= HS_ACK;
        else if (setup_q) hs_q <= HS_NONE;
        else             hs_q <= HS_NAK;
      end else if (busy_q && byte_valid_i && (cnt_q != '1)) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (tok_valid_i) begin
        busy_q  <= 1'b1;
        held_q  <= held_d;
        setup_q <= tok_setup_i;
        ep_q    <= tok_ep_i;
        id_q    <= av_id_i;
        cnt_q   <= '0;
      end
    end
  end

  p_no_write_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !wr_en_o);
  p_setup_no_nak_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_q && hs_q == HS_NAK) |-> $past(!setup_q));
  p_bad_crc_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && eop_i && !crc_ok_i) |=> (hs_valid_q && hs_q == HS_NONE));
  p_hs_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_q |-> $past(fin));
endmodule

// File: rtl/usb_rx_buf_mgr.sv
module usb_rx_buf_mgr import usb_rx_pkg::*; #(
  parameter int MEM_BYTES  = 2048,
  parameter int MAX_PKT    = 64,
  parameter int NUM_EP     = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int ID_W   = $clog2(MEM_BYTES / MAX_PKT),
  localparam int OFF_W  = $clog2(MAX_PKT),
  localparam int LEN_W  = OFF_W + 1,
  localparam int EP_W   = $clog2(NUM_EP),
  localparam int ADDR_W = ID_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_valid_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              tok_setup_i,
  input  logic              byte_valid_i,
  input  logic              eop_i,
  input  logic              crc_ok_i,
  input  logic [NUM_EP-1:0] out_en_i,
  input  logic              av_push_i,
  input  logic [ID_W-1:0]   av_id_i,
  output logic              av_full_o,
  output logic              av_empty_o,
  input  logic              rx_pop_i,
  output logic [ID_W-1:0]   rx_id_o,
  output logic [LEN_W-1:0]  rx_len_o,
  output logic [EP_W-1:0]   rx_ep_o,
  output logic              rx_setup_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic              pkt_rcvd_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              hs_valid_o,
  output logic [1:0]        hs_o
);
  localparam int DW = 1 + EP_W + LEN_W + ID_W;

  logic [ID_W-1:0]  head_id, d_id;
  logic [LEN_W-1:0] d_len;
  logic [EP_W-1:0]  d_ep;
  logic             d_setup, av_pop, rx_push;
  logic [DW-1:0]    rx_din, rx_dout;
  hs_e              hs;

  rx_sfifo #(.WIDTH(ID_W), .DEPTH(FIFO_DEPTH)) i_av_fifo (
    .clk_i, .rst_ni,
    .push_i (av_push_i),
    .data_i (av_id_i),
    .pop_i  (av_pop),
    .data_o (head_id),
    .full_o (av_full_o),
    .empty_o(av_empty_o)
  );

  rx_pkt_ctrl #(.NUM_EP(NUM_EP), .ID_W(ID_W), .OFF_W(OFF_W)) i_ctrl (
    .clk_i, .rst_ni,
    .tok_valid_i, .tok_ep_i, .tok_setup_i, .byte_valid_i, .eop_i, .crc_ok_i,
    .out_en_i,
    .av_empty_i(av_empty_o),
    .av_id_i   (head_id),
    .rx_full_i (rx_full_o),
    .wr_en_o,
    .wr_addr_o,
    .hs_valid_o,
    .hs_o      (hs),
    .av_pop_o  (av_pop),
    .rx_push_o (rx_push),
    .d_id_o    (d_id),
    .d_len_o   (d_len),
    .d_ep_o    (d_ep),
    .d_setup_o (d_setup)
  );

  assign hs_o   = hs;
  assign rx_din = {d_setup, d_ep, d_len, d_id};

  rx_sfifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .data_i (rx_din),
    .pop_i  (rx_pop_i),
    .data_o (rx_dout),
    .full_o (rx_full_o),
    .empty_o(rx_empty_o)
  );

  assign {rx_setup_o, rx_ep_o, rx_len_o, rx_id_o} = rx_dout;
  assign pkt_rcvd_o = !rx_empty_o;

  p_pop_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    av_pop |-> !av_empty_o);
  p_push_room_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> !rx_full_o);
endmodule

// File: tb/test_usb_rx_buf_mgr.sv
`timescale 1ns/100ps
module test_usb_rx_buf_mgr;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tok_valid = 0, tok_setup = 0, byte_valid = 0, eop = 0, crc_ok = 0;
  logic [3:0]  tok_ep = 0;
  logic [15:0] out_en = '1;
  logic        av_push = 0, rx_pop = 0;
  logic [4:0]  av_id = 0;
  logic        av_full, av_empty, rx_full, rx_empty, pkt_rcvd, rx_setup, wr_en, hs_valid;
  logic [4:0]  rx_id;
  logic [6:0]  rx_len;
  logic [3:0]  rx_ep;
  logic [10:0] wr_addr;
  logic [1:0]  hs;

  int n_chk = 0, n_fail = 0;
  int av_q[$], rq_id[$], rq_len[$], rq_ep[$], rq_st[$];

  always #2.5 clk = ~clk;

  usb_rx_buf_mgr i_usb_rx_buf_mgr (
    .clk_i(clk), .rst_ni(rst_n),
    .tok_valid_i(tok_valid), .tok_ep_i(tok_ep), .tok_setup_i(tok_setup),
    .byte_valid_i(byte_valid), .eop_i(eop), .crc_ok_i(crc_ok), .out_en_i(out_en),
    .av_push_i(av_push), .av_id_i(av_id), .av_full_o(av_full), .av_empty_o(av_empty),
    .rx_pop_i(rx_pop), .rx_id_o(rx_id), .rx_len_o(rx_len), .rx_ep_o(rx_ep),
    .rx_setup_o(rx_setup), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .pkt_rcvd_o(pkt_rcvd), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .hs_valid_o(hs_valid), .hs_o(hs)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hs(bit good, bit held, bit setup);
    if (!good) return 0;
    if (held) return 1;
    return setup ? 0 : 2;
  endfunction

  task automatic status_chk();
    chk("R10 av_empty", int'(av_empty), int'(av_q.size() == 0));
    chk("R10 av_full", int'(av_full), int'(av_q.size() == 4));
    chk("R10 rx_full", int'(rx_full), int'(rq_id.size() == 4));
    chk("R7 pkt_rcvd", int'(pkt_rcvd), int'(rq_id.size() > 0));
  endtask

  task automatic send_pkt(input int ep, input bit setup, input int len, input bit good);
    bit held = (av_q.size() > 0) && (rq_id.size() < 4) && (setup || out_en[ep]);
    int id = held ? av_q[0] : 0;
    int e;
    string tag;
    @(negedge clk);
    tok_valid = 1; tok_ep = 4'(ep); tok_setup = setup;
    @(negedge clk);
    tok_valid = 0;
    for (int i = 0; i < len + 2; i++) begin
      byte_valid = 1;
      #1;
      chk(held ? "R6 wr_en" : "R8 wr_en off", int'(wr_en), int'(held && i < 64));
      if (held && i < 64) chk("R1 wr_addr", int'(wr_addr), id * 64 + i);
      @(negedge clk);
      byte_valid = 0;
    end
    eop = 1; crc_ok = good;
    @(negedge clk);
    eop = 0; crc_ok = 0;
    e = exp_hs(good, held, setup);
    if (!good) tag = "R4 hs";
    else if (held) tag = "R5 hs";
    else if (setup) tag = "R3 hs";
    else if (!out_en[ep]) tag = "R8 hs";
    else tag = "R2 hs";
    chk("R11 hs_valid", int'(hs_valid), 1);
    chk(tag, int'(hs), e);
    if (good && held) begin
      void'(av_q.pop_front());
      rq_id.push_back(id); rq_len.push_back(len);
      rq_ep.push_back(ep); rq_st.push_back(int'(setup));
    end
    status_chk();
    @(negedge clk);
    chk("R11 hs pulse", int'(hs_valid), 0);
  endtask

  task automatic sw_push(input int id);
    @(negedge clk);
    av_push = 1; av_id = 5'(id);
    @(negedge clk);
    av_push = 0;
    if (av_q.size() < 4) av_q.push_back(id);
    status_chk();
  endtask

  task automatic sw_pop();
    @(negedge clk);
    if (rq_id.size() > 0) begin
      chk("R5 rx_id", int'(rx_id), rq_id[0]);
      chk("R6 rx_len", int'(rx_len), rq_len[0]);
      chk("R5 rx_ep", int'(rx_ep), rq_ep[0]);
      chk("R5 rx_setup", int'(rx_setup), rq_st[0]);
    end
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
    if (rq_id.size() > 0) begin
      void'(rq_id.pop_front()); void'(rq_len.pop_front());
      void'(rq_ep.pop_front()); void'(rq_st.pop_front());
    end
    status_chk();
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R7 reset pkt_rcvd", int'(pkt_rcvd), 0);
    chk("R10 reset av_empty", int'(av_empty), 1);
    chk("R10 reset rx_empty", int'(rx_empty), 1);
    chk("R11 reset hs_valid", int'(hs_valid), 0);

    // no free buffer
    send_pkt(1, 0, 8, 1);   // R2 NAK
    send_pkt(1, 1, 8, 1);   // R3 silent
    sw_pop();               // R10 pop from empty ignored
    // fill free FIFO, fifth push ignored (R10)
    sw_push(31); sw_push(0); sw_push(7); sw_push(3); sw_push(9);
    out_en = 16'hffdf;
    send_pkt(5, 0, 4, 1);   // R8 NAK, R9 id kept
    send_pkt(5, 1, 8, 1);   // SETUP ignores enable
    send_pkt(2, 0, 12, 0);  // R4 bad CRC
    send_pkt(2, 0, 0, 0);   // R4
    send_pkt(1, 0, 0, 1);   // R6 zero length, id 0
    send_pkt(2, 0, 64, 1);  // R6 CRC bytes past buffer end, id 7
    send_pkt(3, 1, 10, 1);  // id 3, rx full
    sw_push(12); sw_push(13);
    send_pkt(4, 0, 6, 1);   // R2 NAK, rx full
    send_pkt(4, 1, 6, 1);   // R3 silent, rx full
    repeat (5) sw_pop();
    out_en = '1;

    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      if (r < 3) sw_push($urandom_range(0, 31));
      if ($urandom_range(0, 9) < 3) sw_pop();
      if ($urandom_range(0, 19) == 0) out_en = 16'($urandom);
      send_pkt($urandom_range(0, 15), $urandom_range(0, 3) == 0,
               $urandom_range(0, 64), $urandom_range(0, 9) != 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule